// File: doc/BRIEF.md
# Ping-Pong Granule Transpose Buffer

This block joins a transform stage to a synthesis filterbank. The transform stage delivers time samples grouped by subband: 18 consecutive words belong to subband 0, the next 18 to subband 1, and so on, 576 words per granule. The filterbank needs the same samples regrouped by time slot: 32 words, one per subband, for slot 0, then 32 for slot 1, and so on up to slot 17.

Storage is split into two halves of 576 words each. One half fills from the input stream while the other drains to the output in transposed order, so the two sides run concurrently. The halves exchange roles only when the filling half is complete and the draining half is empty. Until then, input ready is held low. Each granule carries a channel/mode tag. The tag is taken from the first word of the granule and is reported with every output word of that granule. Both streams use a valid/ready handshake.

Top module: `granule_transpose_buf`

## Requirements
- R1: While reset is applied and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A word is taken only in a cycle with `in_valid` and `in_ready` both high. The k-th word taken in a granule (k = 0..575) is subband k/18, time slot k%18.
- R3: Output word j of a granule (j = 0..575) is time slot j/32, subband j%32. It is therefore input word (j%32)*18 + j/32 of that granule, and granules leave in the order they arrived.
- R4: `out_group_end` is 1 exactly on output words whose subband is 31. `out_granule_end` is 1 exactly on output word 575, and `out_valid` drops after that word is taken.
- R5: After the 576th word of a granule is taken, `in_ready` stays 0 until the other half has been fully drained. `in_ready` only falls after a whole multiple of 576 words have been taken.
- R6: When one half is full and the other is empty, the roles swap on the next clock edge. In the following cycle `in_ready` and `out_valid` are both 1, so the idle gap is exactly one cycle.
- R7: `out_tag` equals the `in_tag` value present on the first word of the granule. `in_tag` on the other 575 words has no effect.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_tag` and `out_group_end` hold their values.
- R9: No output appears before a full granule has been written. After 575 words `out_valid` is still 0, and the first output word appears two cycles after the edge that takes word 576.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word can be taken this cycle |
| in_data | input | DATA_W (32) | Time-domain sample, subband-major order |
| in_tag | input | TAG_W (3) | Channel/mode tag, sampled on the first word of a granule |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word this cycle |
| out_data | output | DATA_W (32) | Sample, time-slot-major order |
| out_tag | output | TAG_W (3) | Tag of the granule being drained |
| out_group_end | output | 1 | Last word (subband 31) of a 32-word time-slot group |
| out_granule_end | output | 1 | Last word of the granule |

## Verification
Four granules are streamed back to back. Each granule has its own data seed and tag, and each pairs a different input gap pattern (none, one idle cycle in three, one in two) with a different output back-pressure pattern (always ready, alternating, three stalls in seven, a long initial stall). Data encodes the input index, so a transpose that uses the wrong stride or swaps the slot and subband counters shows up as a specific wrong index. The long stall forces the write half to fill while the read half is still busy, which separates correct swap gating from a swap that happens as soon as the write half is full. The gap-free and always-ready cases pin the one-cycle swap bubble. A directed run after a mid-stream reset writes exactly 575 and then 576 words, to check the first-output boundary cycle by cycle.

// File: rtl/gtb_pkg.sv
package gtb_pkg;

  // which half of the double buffer a role is using
  typedef enum logic {HALF_A = 1'b0, HALF_B = 1'b1} half_t;

  // storage slot of (subband, time slot) inside one half
  function automatic int slot_addr(input int sb, input int t, input int slots_per_sb);
    return sb * slots_per_sb + t;
  endfunction

  function automatic half_t other_half(input half_t h);
    return (h == HALF_A) ? HALF_B : HALF_A;
  endfunction

endpackage

// File: rtl/gtb_write_seq.sv
module gtb_write_seq #(
  parameter int DEPTH = 576,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          swap,
  output logic [AW-1:0] wr_addr,
  output logic          wr_full
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_addr <= '0;
      wr_full <= 1'b0;
    end else if (swap) begin
      wr_full <= 1'b0;
    end else if (accept) begin
      if (wr_addr == LAST) begin
        wr_addr <= '0;
        wr_full <= 1'b1;
      end else begin
        wr_addr <= wr_addr + 1'b1;
      end
    end
  end

  AST_WR_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr <= LAST);  // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full && !swap |=> wr_full);  // R5
  AST_FULL_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full |-> wr_addr == '0);  // R2

endmodule

// File: rtl/gtb_read_scan.sv
module gtb_read_scan
  import gtb_pkg::*;
#(
  parameter int NUM_SB = 32,
  parameter int NUM_T  = 18,
  parameter int AW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ready,
  output logic          busy,
  output logic [AW-1:0] rd_addr,
  output logic          group_end,
  output logic          granule_end
);

  localparam int SBW = $clog2(NUM_SB);
  localparam int TW  = $clog2(NUM_T);
  localparam logic [SBW-1:0] SB_LAST = SBW'(NUM_SB - 1);
  localparam logic [TW-1:0]  T_LAST  = TW'(NUM_T - 1);

  logic [SBW-1:0] sb;
  logic [TW-1:0]  t;
  logic           step;

  assign step        = busy && ready;
  assign group_end   = (sb == SB_LAST);
  assign granule_end = group_end && (t == T_LAST);
  assign rd_addr     = AW'(slot_addr(int'(sb), int'(t), NUM_T));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sb   <= '0;
      t    <= '0;
    end else if (start) begin
      busy <= 1'b1;
      sb   <= '0;
      t    <= '0;
    end else if (step) begin
      if (granule_end) begin
        busy <= 1'b0;
        sb   <= '0;
        t    <= '0;
      end else if (group_end) begin
        sb <= '0;
        t  <= t + 1'b1;
      end else begin
        sb <= sb + 1'b1;
      end
    end
  end

  AST_SCAN_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    step && granule_end |=> !busy);  // R4
  AST_START_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && rd_addr == '0);  // R3
  AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ready |=> busy && $stable(rd_addr));  // R8

endmodule

// File: rtl/gtb_store.sv
module gtb_store
  import gtb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 576,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              wr_en,
  input  half_t             wr_half,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  half_t             rd_half,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] half_q [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_half == half_t'(h))) mem[wr_addr] <= wr_data;
    end
    assign half_q[h] = mem[rd_addr];
  end

  assign rd_data = half_q[rd_half];

endmodule

// File: rtl/granule_transpose_buf.sv
module granule_transpose_buf
  import gtb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3,
  parameter int NUM_SB = 32,
  parameter int NUM_T  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_group_end,
  output logic              out_granule_end
);

  localparam int DEPTH = NUM_SB * NUM_T;
  localparam int AW    = $clog2(DEPTH);

  // named internal events
  logic          accept;
  logic          swap;
  logic          first_word;
  logic          wr_full;
  logic          rd_busy;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  half_t         wsel;
  logic [TAG_W-1:0] wtag;
  logic [TAG_W-1:0] rtag;

  assign in_ready   = !wr_full;
  assign accept     = in_valid && in_ready;
  assign swap       = wr_full && !rd_busy;
  assign first_word = accept && (wr_addr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wsel <= HALF_A;
      wtag <= '0;
      rtag <= '0;
    end else begin
      if (swap) begin
        wsel <= other_half(wsel);
        rtag <= wtag;
      end
      if (first_word) wtag <= in_tag;
    end
  end

  gtb_write_seq #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .swap    (swap),
    .wr_addr (wr_addr),
    .wr_full (wr_full)
  );

  gtb_read_scan #(.NUM_SB(NUM_SB), .NUM_T(NUM_T), .AW(AW)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (swap),
    .ready       (out_ready),
    .busy        (rd_busy),
    .rd_addr     (rd_addr),
    .group_end   (out_group_end),
    .granule_end (out_granule_end)
  );

  gtb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk     (clk),
    .wr_en   (accept),
    .wr_half (wsel),
    .wr_addr (wr_addr),
    .wr_data (in_data),
    .rd_half (other_half(wsel)),
    .rd_addr (rd_addr),
    .rd_data (out_data)
  );

  assign out_valid = rd_busy;
  assign out_tag   = rtag;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_tag)
      && $stable(out_group_end));  // R8
  AST_FIRST_OUT_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(!in_ready));  // R9
  AST_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_granule_end |=> $stable(out_tag));  // R7
  AST_SWAP_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && !out_valid |=> in_ready && out_valid);  // R6

endmodule

// File: tb/granule_transpose_buf_tb.sv
module granule_transpose_buf_tb;

  localparam int DW = 32, TGW = 3, NSB = 32, NT = 18, DEPTH = 576, NG = 4;
  // vector fields: tag[14:12] seed[11:4] input gap mode[3:2] output stall mode[1:0]
  localparam bit [14:0] VEC [NG] = '{
    {3'd5, 8'h11, 2'd0, 2'd0},
    {3'd2, 8'hA3, 2'd1, 2'd3},
    {3'd7, 8'h3C, 2'd2, 2'd1},
    {3'd0, 8'hF0, 2'd0, 2'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [TGW-1:0] in_tag = '0;
  logic in_ready, out_valid, out_group_end, out_granule_end;
  logic [DW-1:0] out_data;
  logic [TGW-1:0] out_tag;

  always #4 clk = ~clk;

  granule_transpose_buf u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_tag(in_tag), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_tag(out_tag), .out_group_end(out_group_end),
    .out_granule_end(out_granule_end));

  int n_chk = 0, n_fail = 0;
  int acc = 0, got = 0;
  bit go = 0, mon_on = 0, done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input bit [7:0] seed, input int k);
    return {seed, seed ^ 8'h5A, 16'(k)};
  endfunction

  function automatic bit ready_pat(input bit [1:0] m, input int c);
    case (m)
      2'd0: return 1'b1;
      2'd1: return (c % 2) == 0;
      2'd2: return (c % 7) >= 3;
      default: return c > 700;
    endcase
  endfunction

  // producer: walks the vector table, one granule per entry
  initial begin
    wait (go);
    @(negedge clk);
    for (int g = 0; g < NG; g++) begin
      for (int k = 0; k < DEPTH; k++) begin
        if ((VEC[g][3:2] == 2'd1 && k % 3 == 2) || (VEC[g][3:2] == 2'd2 && k % 2 == 1)) begin
          in_valid = 1'b0;
          @(negedge clk);
        end
        in_valid = 1'b1;
        in_data  = word_of(VEC[g][11:4], k);
        in_tag   = (k == 0) ? VEC[g][14:12] : ~VEC[g][14:12];  // R7: later tags differ
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        acc++;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
  end

  // consumer: checks transposed order, tags and markers per granule
  initial begin
    int ccyc = 0, e_dat = 0, e_tag = 0, e_grp = 0, e_gra = 0;
    logic [DW-1:0] fa = '0, fe = '0;
    bit seen = 0, stalled = 0, hold_bad = 0;
    int n_stall = 0;
    logic [DW-1:0] snap = '0;
    wait (go);
    while (got < NG * DEPTH) begin
      int g, j, t, sb;
      @(negedge clk);
      g = got / DEPTH; j = got % DEPTH; t = j / NSB; sb = j % NSB;
      if (stalled) begin
        if (!out_valid || out_data != snap) hold_bad = 1;
      end
      ccyc++;
      out_ready = ready_pat(VEC[g][1:0], ccyc);
      if (out_valid && !seen) begin
        seen = 1;
        chk(acc >= DEPTH, "R9", "words written before first output", acc, DEPTH);
      end
      stalled = out_valid && !out_ready;
      if (stalled) begin snap = out_data; n_stall++; end
      if (out_valid && out_ready) begin
        logic [DW-1:0] ex;
        ex = word_of(VEC[g][11:4], sb * NT + t);
        if (out_data != ex) begin
          if (e_dat == 0) begin fa = out_data; fe = ex; end
          e_dat++;
        end
        if (out_tag != VEC[g][14:12]) e_tag++;
        if (out_group_end != (sb == NSB - 1)) e_grp++;
        if (out_granule_end != (j == DEPTH - 1)) e_gra++;
        got++;
        if (j == DEPTH - 1) begin
          chk(e_dat == 0, "R3", $sformatf("granule %0d transposed data", g), fa, fe);
          chk(e_tag == 0, "R7", $sformatf("granule %0d tag mismatches", g), e_tag, 0);
          chk(e_grp == 0, "R4", $sformatf("granule %0d group end mismatches", g), e_grp, 0);
          chk(e_gra == 0, "R4", $sformatf("granule %0d granule end mismatches", g), e_gra, 0);
          e_dat = 0; e_tag = 0; e_grp = 0; e_gra = 0; ccyc = 0;
        end
      end
    end
    chk(!hold_bad && n_stall > 0, "R8", "output held under stall", hold_bad, 0);
    done = 1;
  end

  // monitor of input ready around swaps
  initial begin
    bit prev = 1;
    int run = 0, max_run = 0, nfall = 0, bad_fall = 0;
    bit first_done = 0;
    wait (go);
    while (!done) begin
      @(negedge clk);
      if (!mon_on) continue;
      if (prev && !in_ready) begin
        nfall++;
        if (acc % DEPTH != 0) bad_fall++;
      end
      if (!in_ready) run++;
      else if (run > 0) begin
        if (!first_done) begin
          first_done = 1;
          chk(run == 1, "R6", "first swap idle cycles", run, 1);
          chk(out_valid == 1'b1, "R6", "out_valid after first swap", out_valid, 1);
        end
        if (run > max_run) max_run = run;
        run = 0;
      end
      prev = in_ready;
    end
    chk(bad_fall == 0 && nfall >= NG, "R5", "ready falls on granule boundaries", bad_fall, 0);
    chk(max_run > 1, "R5", "write blocked while read half busy", max_run, 2);
  end

  task automatic put_word(input int k, input bit [2:0] tag);
    in_valid = 1'b1;
    in_data  = word_of(8'h77, k);
    in_tag   = tag;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", "state after reset", {out_valid, in_ready}, 2'b01);
    mon_on = 1;
    go = 1;
    wait (done);
    mon_on = 0;
    @(negedge clk);
    // directed: partial granule then reset
    out_ready = 1'b0;
    for (int k = 0; k < 10; k++) put_word(k, 3'd1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", "state after mid-stream reset", {out_valid, in_ready}, 2'b01);
    // directed: 575 / 576 boundary
    for (int k = 0; k < DEPTH - 1; k++) put_word(k, (k == 0) ? 3'd6 : 3'd2);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "no output after 575 words", out_valid, 0);
    chk(in_ready == 1'b1, "R2", "ready before last word", in_ready, 1);
    in_valid = 1'b1; in_data = word_of(8'h77, DEPTH - 1); in_tag = 3'd3;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0 && out_valid == 1'b0, "R5", "full half blocks input", {in_ready, out_valid}, 2'b00);
    @(negedge clk);
    chk(out_valid == 1'b1, "R9", "first output two edges after word 576", out_valid, 1);
    chk(out_data == word_of(8'h77, 0), "R3", "first output word", out_data, word_of(8'h77, 0));
    chk(out_tag == 3'd6, "R7", "tag from first word only", out_tag, 6);
    @(negedge clk);
    chk(out_valid == 1'b1 && out_data == word_of(8'h77, 0), "R8", "held without ready", out_data, word_of(8'h77, 0));
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_data == word_of(8'h77, NT), "R3", "second output is subband 1 slot 0", out_data, word_of(8'h77, NT));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", got, NG * DEPTH);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule